// File: doc/BRIEF.md
# Isochronous Transmit Packet Queue

This block sits between a DMA writer and a link-side reader on the isochronous transmit path. The writer pushes 32-bit quadlets, and it marks the last quadlet of every packet with an end-of-packet flag. The reader pulls quadlets one at a time. The controller counts the complete packets held in storage. A reader that is between packets may start a new one only when that count is non-zero, so a packet is never begun before all of it has arrived.

If the link aborts a packet partway through (an underrun), the controller stops presenting data. It then drains the rest of that packet from storage, one quadlet per cycle, up to and including its end-of-packet quadlet. Draining that quadlet lowers the packet count, so the count stays true and the queue cannot fall into a chain of repeated underruns.

Each underrun also steps an 8-bit counter that software can load. The counter raises a sticky interrupt when it climbs to all ones. A flush request empties the queue. Its busy flag reads 1 while the flush is in progress and then clears by itself.

Top module: `itq_tx_ctrl`

## Requirements
- R1: After reset, fifo_empty is 1, and wr_full, wr_hiwat, pkt_avail, rd_vld, urc_val, urc_irq and flush_busy are all 0.
- R2: A reader between packets is served only while at least one quadlet flagged wr_eop=1 is stored. Until then rd_en is ignored and rd_vld stays 0.
- R3: Quadlets come out in write order, with rd_data and rd_eop presented together with rd_vld one cycle after the accepted rd_en.
- R4: pkt_avail is 1 exactly when storage holds at least one quadlet written with wr_eop=1. It follows the push or pop by one cycle.
- R5: An end-of-packet push and an end-of-packet pop in the same cycle leave the packet count unchanged.
- R6: A lnk_underrun pulse inside a packet discards the remaining quadlets of that packet, up to and including its end quadlet, without raising rd_vld. The packet count then drops by one.
- R7: urc_ld loads urc_ld_val into urc_val. Each underrun adds one to urc_val, saturating at 8'hFF. urc_irq sets when an underrun takes urc_val from 8'hFE to 8'hFF, stays set, and clears on irq_clr.
- R8: A flush_req pulse makes flush_busy read 1 on the next cycle and 0 the cycle after. The flush clears storage, the packet count and any pending discard, and pushes and pops are ignored while flush_busy is 1.
- R9: A write while wr_full=1 is not stored and pulses wr_drop one cycle later. wr_full is 1 exactly when all 2**AW entries are occupied.
- R10: wr_hiwat is 1 when the stored quadlet count is at least hiwat_lvl.
- R11: When storage goes empty and a push arrives on the very next clock, fifo_empty reads 1 for exactly one cycle and then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push one quadlet |
| wr_data | input | DW | Quadlet to push |
| wr_eop | input | 1 | Pushed quadlet ends its packet |
| hiwat_lvl | input | AW+1 | High-water threshold in quadlets |
| wr_full | output | 1 | Storage full |
| wr_hiwat | output | 1 | Level at or above threshold |
| wr_drop | output | 1 | A write was refused because storage was full |
| rd_en | input | 1 | Link requests the next quadlet |
| rd_data | output | DW | Quadlet delivered |
| rd_eop | output | 1 | Delivered quadlet ends its packet |
| rd_vld | output | 1 | rd_data and rd_eop are valid |
| pkt_avail | output | 1 | At least one complete packet is stored |
| fifo_empty | output | 1 | Storage empty |
| lnk_underrun | input | 1 | Link aborted the current packet |
| urc_ld | input | 1 | Load the underrun counter |
| urc_ld_val | input | 8 | Value to load |
| urc_val | output | 8 | Underrun counter |
| urc_irq | output | 1 | Sticky underflow interrupt |
| irq_clr | input | 1 | Clear urc_irq |
| flush_req | input | 1 | Start a flush |
| flush_busy | output | 1 | Flush in progress |

## Verification
A packet count that has drifted shows up at pkt_avail one cycle after the push or pop that should have moved it. After an underrun it shows more clearly: a single non-final quadlet written afterwards would wrongly report a complete packet. A discard state that stays set, or that clears too early, changes the read stream within a few cycles. Quadlets then go missing from the scoreboard, or quadlets that should have been discarded appear in it, and a flush during a discard confirms that the next packet comes out whole.

// File: rtl/itq_pkg.sv
package itq_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_PKT  = 2'd1,
    RS_DISC = 2'd2
  } rdst_t;

  localparam int URC_W = 8;
endpackage

// File: rtl/itq_ram.sv
module itq_ram #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/itq_urun_ctr.sv
module itq_urun_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] val,
  output logic         irq
);
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] NEAR = TOP - W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
      irq <= 1'b0;
    end else begin
      if (ld) val <= ld_val;
      else if (inc && val != TOP) val <= val + W'(1);

      if (inc && !ld && val == NEAR) irq <= 1'b1;
      else if (clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/itq_tx_ctrl.sv
module itq_tx_ctrl
  import itq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              wr_eop,
  input  logic [AW:0]       hiwat_lvl,
  output logic              wr_full,
  output logic              wr_hiwat,
  output logic              wr_drop,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  output logic              rd_eop,
  output logic              rd_vld,
  output logic              pkt_avail,
  output logic              fifo_empty,
  input  logic              lnk_underrun,
  input  logic              urc_ld,
  input  logic [URC_W-1:0]  urc_ld_val,
  output logic [URC_W-1:0]  urc_val,
  output logic              urc_irq,
  input  logic              irq_clr,
  input  logic              flush_req,
  output logic              flush_busy
);
  localparam int          DEPTH    = 1 << AW;
  localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE      = (AW+1)'(1);

  logic [AW-1:0]    wp, rp;
  logic [AW:0]      lvl, lvl_n;
  logic [AW:0]      pcnt, pcnt_n;
  logic [DEPTH-1:0] eopf;
  rdst_t            rst_q, rst_n;

  logic is_empty, is_full;
  logic push, pop, rd_take, disc_take, urun, pop_eop;

  assign is_empty = (lvl == '0);
  assign is_full  = (lvl == LVL_FULL);
  assign pop_eop  = eopf[rp];

  assign push      = wr_en && !flush_busy && !is_full;
  assign urun      = lnk_underrun && !flush_busy && (rst_q == RS_PKT);
  assign rd_take   = rd_en && !flush_busy && !urun && !is_empty &&
                     ((rst_q == RS_PKT) || (rst_q == RS_IDLE && pcnt != '0));
  assign disc_take = (rst_q == RS_DISC) && !flush_busy && !is_empty;
  assign pop       = rd_take || disc_take;

  always_comb begin
    if (flush_busy) begin
      lvl_n  = '0;
      pcnt_n = '0;
    end else begin
      lvl_n  = lvl + (push ? ONE : '0) - (pop ? ONE : '0);
      pcnt_n = pcnt + ((push && wr_eop) ? ONE : '0) - ((pop && pop_eop) ? ONE : '0);
    end
  end

  always_comb begin
    rst_n = rst_q;
    if (flush_busy)                                   rst_n = RS_IDLE;
    else if (urun)                                    rst_n = RS_DISC;
    else if (rd_take)                                 rst_n = pop_eop ? RS_IDLE : RS_PKT;
    else if (disc_take && pop_eop)                    rst_n = RS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp         <= '0;
      rp         <= '0;
      lvl        <= '0;
      pcnt       <= '0;
      rst_q      <= RS_IDLE;
      flush_busy <= 1'b0;
      wr_full    <= 1'b0;
      wr_hiwat   <= 1'b0;
      wr_drop    <= 1'b0;
      fifo_empty <= 1'b1;
      pkt_avail  <= 1'b0;
      rd_vld     <= 1'b0;
      rd_eop     <= 1'b0;
    end else begin
      flush_busy <= flush_req;
      if (flush_busy) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push) wp <= wp + AW'(1);
        if (pop)  rp <= rp + AW'(1);
      end
      lvl        <= lvl_n;
      pcnt       <= pcnt_n;
      rst_q      <= rst_n;
      wr_full    <= (lvl_n == LVL_FULL);
      wr_hiwat   <= (lvl_n >= hiwat_lvl);
      wr_drop    <= wr_en && !flush_busy && is_full;
      fifo_empty <= (lvl_n == '0);
      pkt_avail  <= (pcnt_n != '0);
      rd_vld     <= rd_take;
      rd_eop     <= rd_take && pop_eop;
    end
  end

  always_ff @(posedge clk) begin
    if (push) eopf[wp] <= wr_eop;
  end

  itq_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (wp),
    .wdata (wr_data),
    .re    (rd_take),
    .raddr (rp),
    .rdata (rd_data)
  );

  itq_urun_ctr #(.W(URC_W)) u_urc (
    .clk    (clk),
    .rst    (rst),
    .ld     (urc_ld),
    .ld_val (urc_ld_val),
    .inc    (urun),
    .clr    (irq_clr),
    .val    (urc_val),
    .irq    (urc_irq)
  );
endmodule

// File: rtl/itq_tx_chk.sv
module itq_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       wr_full,
  input logic       wr_drop,
  input logic       flush_req,
  input logic       flush_busy,
  input logic       fifo_empty,
  input logic       pkt_avail,
  input logic       rd_vld,
  input logic       urc_irq,
  input logic [7:0] urc_val
);
  assert_drop_on_full_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_full && !flush_busy) |=> wr_drop);

  assert_drop_needs_full_R9: assert property (@(posedge clk) disable iff (rst)
    wr_drop |-> $past(wr_full));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush_busy |=> (fifo_empty && !pkt_avail));

  assert_flush_selfclear_R8: assert property (@(posedge clk) disable iff (rst)
    !flush_req |=> !flush_busy);

  assert_irq_at_top_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(urc_irq) |-> (urc_val == 8'hFF));

  assert_vld_needs_data_R3: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(!fifo_empty));
endmodule

bind itq_tx_ctrl itq_tx_chk u_itq_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_full    (wr_full),
  .wr_drop    (wr_drop),
  .flush_req  (flush_req),
  .flush_busy (flush_busy),
  .fifo_empty (fifo_empty),
  .pkt_avail  (pkt_avail),
  .rd_vld     (rd_vld),
  .urc_irq    (urc_irq),
  .urc_val    (urc_val)
);

// File: tb/test_itq_tx_ctrl.sv
module test_itq_tx_ctrl;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, wr_eop = 0, rd_en = 0, lnk_underrun = 0;
  logic urc_ld = 0, irq_clr = 0, flush_req = 0;
  logic [DW-1:0] wr_data = '0;
  logic [AW:0]   hiwat_lvl = 5'd8;
  logic [7:0]    urc_ld_val = '0;
  logic wr_full, wr_hiwat, wr_drop, rd_eop, rd_vld, pkt_avail, fifo_empty;
  logic urc_irq, flush_busy;
  logic [DW-1:0] rd_data;
  logic [7:0]    urc_val;

  int nchk = 0, nbad = 0;
  bit done = 0;
  logic [DW:0] sb[$];

  always #5 clk = ~clk;

  itq_tx_ctrl #(.DW(DW), .AW(AW)) i_itq_tx_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
    .hiwat_lvl(hiwat_lvl), .wr_full(wr_full), .wr_hiwat(wr_hiwat), .wr_drop(wr_drop),
    .rd_en(rd_en), .rd_data(rd_data), .rd_eop(rd_eop), .rd_vld(rd_vld),
    .pkt_avail(pkt_avail), .fifo_empty(fifo_empty), .lnk_underrun(lnk_underrun),
    .urc_ld(urc_ld), .urc_ld_val(urc_ld_val), .urc_val(urc_val), .urc_irq(urc_irq),
    .irq_clr(irq_clr), .flush_req(flush_req), .flush_busy(flush_busy)
  );

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare each delivered quadlet with the scoreboard head (R3)
  always @(negedge clk) begin
    if (!rst && rd_vld) begin
      if (sb.size() == 0) begin
        nchk++; nbad++;
        $display("FAIL R3 unexpected quadlet actual=%h expected=none", {rd_eop, rd_data});
      end else begin
        chk("R3 stream", {rd_eop, rd_data}, sb.pop_front());
      end
    end
  end

  task automatic push(input logic [DW-1:0] d, input logic e, input bit exp);
    wr_en = 1; wr_data = d; wr_eop = e;
    if (exp) sb.push_back({e, d});
    @(negedge clk);
    wr_en = 0; wr_eop = 0;
  endtask

  task automatic rd(input int n);
    rd_en = 1;
    repeat (n) @(negedge clk);
    rd_en = 0;
  endtask

  task automatic underrun();
    lnk_underrun = 1;
    @(negedge clk);
    lnk_underrun = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", wr_full, 0);
    chk("R1 hiwat", wr_hiwat, 0);
    chk("R1 pkt_avail", pkt_avail, 0);
    chk("R1 urc_val", urc_val, 0);
    chk("R1 irq", urc_irq, 0);
    chk("R1 busy", flush_busy, 0);
    chk("R1 vld", rd_vld, 0);

    // R2 gating: partial packet is not served
    for (int i = 0; i < 3; i++) push(32'h100 + i, 0, 1);
    chk("R4 partial no pkt", pkt_avail, 0);
    rd_en = 1;
    @(negedge clk); chk("R2 gated", rd_vld, 0);
    @(negedge clk); chk("R2 gated", rd_vld, 0);
    rd_en = 0;
    push(32'h103, 1, 1);
    chk("R4 pkt after eop", pkt_avail, 1);
    for (int i = 0; i < 2; i++) push(32'h200 + i, i == 1, 1);
    rd(4);
    chk("R4 one pkt left", pkt_avail, 1);
    rd(2);
    @(negedge clk);
    chk("R4 none left", pkt_avail, 0);
    chk("R4 empty", fifo_empty, 1);

    // R5 simultaneous end push and end pop
    push(32'h300, 1, 1);
    rd_en = 1; wr_en = 1; wr_data = 32'h301; wr_eop = 1; sb.push_back({1'b1, 32'h301});
    @(negedge clk);
    rd_en = 0; wr_en = 0; wr_eop = 0;
    chk("R5 count kept", pkt_avail, 1);
    rd(1);
    chk("R11 empty seen", fifo_empty, 1);
    push(32'h302, 1, 1);
    chk("R11 not stuck empty", fifo_empty, 0);
    chk("R4 new pkt", pkt_avail, 1);
    rd(1);
    @(negedge clk);

    // R6 underrun discard
    for (int i = 0; i < 4; i++) push(32'h400 + i, i == 3, i < 2);
    for (int i = 0; i < 2; i++) push(32'h500 + i, i == 1, 1);
    rd(2);
    @(negedge clk);
    underrun();
    chk("R7 urc step", urc_val, 1);
    repeat (3) begin
      chk("R6 no vld in discard", rd_vld, 0);
      @(negedge clk);
    end
    rd(2);
    @(negedge clk);
    chk("R6 drained", fifo_empty, 1);
    push(32'h600, 0, 1);
    chk("R6 count decremented", pkt_avail, 0);
    push(32'h601, 1, 1);
    rd(2);
    @(negedge clk);

    // R7 underrun counter and interrupt
    urc_ld = 1; urc_ld_val = 8'hFE;
    @(negedge clk);
    urc_ld = 0;
    chk("R7 load", urc_val, 8'hFE);
    chk("R7 irq idle", urc_irq, 0);
    push(32'h700, 0, 1); push(32'h701, 1, 0);
    rd(1);
    underrun();
    chk("R7 reach top", urc_val, 8'hFF);
    chk("R7 irq set", urc_irq, 1);
    repeat (2) @(negedge clk);
    chk("R7 irq sticky", urc_irq, 1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    chk("R7 irq clear", urc_irq, 0);
    push(32'h710, 0, 1); push(32'h711, 1, 0);
    rd(1);
    underrun();
    chk("R7 saturate", urc_val, 8'hFF);
    chk("R7 no refire", urc_irq, 0);
    repeat (2) @(negedge clk);

    // R8 flush
    for (int i = 0; i < 3; i++) push(32'h800 + i, i == 2, 0);
    flush_req = 1;
    @(negedge clk);
    flush_req = 0;
    chk("R8 busy", flush_busy, 1);
    @(negedge clk);
    chk("R8 self clear", flush_busy, 0);
    chk("R8 empty", fifo_empty, 1);
    chk("R8 no pkt", pkt_avail, 0);
    rd_en = 1;
    @(negedge clk); chk("R8 nothing to read", rd_vld, 0);
    rd_en = 0;
    // flush during a discard
    for (int i = 0; i < 4; i++) push(32'h900 + i, i == 3, i == 0);
    rd(1);
    underrun();
    flush_req = 1;
    @(negedge clk);
    flush_req = 0;
    @(negedge clk);
    for (int i = 0; i < 2; i++) push(32'hA00 + i, i == 1, 1);
    chk("R8 discard cleared", pkt_avail, 1);
    rd(2);
    @(negedge clk);

    // R9 / R10 fill and overflow
    for (int i = 0; i < 7; i++) push(32'hB00 + i, 0, 1);
    chk("R10 below", wr_hiwat, 0);
    push(32'hB07, 0, 1);
    chk("R10 at threshold", wr_hiwat, 1);
    for (int i = 8; i < 16; i++) push(32'hB00 + i, i == 15, 1);
    chk("R9 full", wr_full, 1);
    push(32'hBFF, 1, 0);
    chk("R9 drop pulse", wr_drop, 1);
    chk("R9 still full", wr_full, 1);
    @(negedge clk);
    chk("R9 drop ends", wr_drop, 0);
    rd(16);
    @(negedge clk);
    chk("R9 dropped not stored", fifo_empty, 1);
    chk("R9 dropped eop absent", pkt_avail, 0);

    repeat (3) @(negedge clk);
    chk("R3 all delivered", sb.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule